// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit up-counters, a lower lane and an upper lane. Each lane has its own compare value, comparator and match output. In split mode each lane is an independent interval timer. Its tick is picked from a bank of one-cycle prescaled enables. The upper lane has one more choice of source: the lower lane's match event. With that source its period is the product of the two compare values.

In cascade mode the two lanes form one 16-bit interval timer. The lower lane counts ticks and its roll-over steps the upper lane, whatever the upper source select holds. The 16-bit compare value is split across the two compare inputs, upper byte and lower byte. The interval interrupt comes from the upper lane. It fires once every `{cmp_hi,cmp_lo}` lower ticks, and both lanes clear together.

All state runs on one system clock. Ticks are clock enables, not derived clocks.

Top module: `dual_tmr8`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, both counts are zero and `match_lo`, `match_hi`, `irq_lo` and `irq_hi` are low.
- R2: In split mode (`mode` other than 2'b01) with its run bit set, a lane steps by one on each active tick. On the tick whose stepped value would equal its compare value, the lane clears to zero instead. At that same clock edge it raises its match output, and its `irq_*` output in split mode, for exactly one cycle.
- R3: A compare value of 8'h00 in split mode gives one match every 256 ticks, and none before the 256th.
- R4: The lower lane's tick is `tick_in[sel_lo]`. The upper lane's tick in split mode is `tick_in[sel_hi]` for a non-zero `sel_hi`, and the lower lane's match event when `sel_hi` is 0.
- R5: In split mode with `sel_hi` = 0, the upper lane matches once every `cmp_lo × cmp_hi` lower ticks. Its count steps at the same edge as each lower match.
- R6: `mode` = 2'b01 selects cascade mode. In it the upper lane steps only when the lower lane rolls over from 8'hFF, and `sel_hi` and `tick_in[sel_hi]` have no effect. Mode codes 2'b00, 2'b10 and 2'b11 all select split mode.
- R7: In cascade mode a match needs the 16-bit stepped value to equal `{cmp_hi,cmp_lo}`. Both lanes then clear at the same edge and a single `irq_hi` pulse is raised. `irq_lo` stays low. `match_lo` only reports the lower comparator and does not clear the lower lane.
- R8: A cleared run bit holds its lane at zero and ignores ticks. Once the bit is set again, counting restarts from zero. In cascade mode both run bits must be set for the pair to count.
- R9: A new compare value takes effect on the next active tick, with no restart of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | NT (4) | Bank of one-cycle prescaled tick enables |
| sel_lo | input | log2(NT) (2) | Tick select for the lower lane |
| sel_hi | input | log2(NT) (2) | Source select for the upper lane; 0 selects the lower match |
| mode | input | 2 | 2'b01 cascade (16-bit), other codes split |
| run_lo | input | 1 | Run enable, lower lane |
| run_hi | input | 1 | Run enable, upper lane |
| cmp_lo | input | CW (8) | Lower compare value |
| cmp_hi | input | CW (8) | Upper compare value |
| cnt_lo | output | CW (8) | Lower count |
| cnt_hi | output | CW (8) | Upper count |
| match_lo | output | 1 | Lower comparator match pulse |
| match_hi | output | 1 | Upper (or 16-bit) match pulse |
| irq_lo | output | 1 | Lower interval interrupt strobe (split mode only) |
| irq_hi | output | 1 | Upper or 16-bit interval interrupt strobe |

## Verification
A wrong count shows on `cnt_lo` or `cnt_hi` at the first sample after the tick that caused it. A wrong clear or a wrong compare shows as a match pulse on the wrong tick, a cycle after the edge. A fault in the upper source select or in the cascade carry shows on `cnt_hi` at the first lower match or roll-over. The 16-bit cases need up to 259 ticks before the interrupt timing can be seen. The 256-tick case shows a missing wrap only at its last tick.

// File: rtl/dual_tmr8_pkg.sv
// Package: shared mode codes for the dual interval timer.
// Assumes a 2-bit mode field; only one code selects cascading.
package dual_tmr8_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT = 2'b00,
        MODE_CASC  = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_RSV3  = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_src_sel.sv
// Upper-lane source selector: select 0 routes the cascade event,
// other values route the matching prescaled tick.
// Assumes tick bit 0 is not reachable from this lane, so it is not an input.
module tmr_src_sel #(
    parameter int NT = 4,
    localparam int SW = $clog2(NT)
) (
    input  logic [NT-1:1] ticks,
    input  logic [SW-1:0] sel,
    input  logic          casc_ev,
    output logic          src
);
    logic [NT-1:0] pool;

    // Build the candidate list and pick one entry.
    always_comb begin
        pool = {ticks, casc_ev};
        src  = pool[sel];
    end
endmodule

// File: rtl/tmr_byte_counter.sv
// One counter lane: steps on inc, clears on clr or when run is low.
// eq reports that the stepped value equals the compare input.
// Assumes inc and clr are single-cycle enables in the clk domain.
module tmr_byte_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         inc,
    input  logic         clr,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         eq
);
    logic [W-1:0] stepped;

    // Candidate next value and its comparison.
    always_comb begin
        stepped = cnt + {{(W-1){1'b0}}, inc};
        eq      = (stepped == cmp);
    end

    // Count register with hold-at-zero and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || clr)  cnt <= '0;
        else if (inc)          cnt <= stepped;
    end
endmodule

// File: rtl/dual_tmr8.sv
// Dual interval timer top: two counter lanes, split or cascaded into 16 bits.
// Assumes tick_in bits are one-cycle enables synchronous to clk.
// Match and interrupt outputs are registered at the edge that clears a lane.
module dual_tmr8
    import dual_tmr8_pkg::*;
#(
    parameter int CW = 8,
    parameter int NT = 4,
    localparam int SW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] tick_in,
    input  logic [SW-1:0] sel_lo,
    input  logic [SW-1:0] sel_hi,
    input  logic [1:0]    mode,
    input  logic          run_lo,
    input  logic          run_hi,
    input  logic [CW-1:0] cmp_lo,
    input  logic [CW-1:0] cmp_hi,
    output logic [CW-1:0] cnt_lo,
    output logic [CW-1:0] cnt_hi,
    output logic          match_lo,
    output logic          match_hi,
    output logic          irq_lo,
    output logic          irq_hi
);
    localparam int LANES = 2;

    logic                      casc;
    logic [LANES-1:0]          run_v, inc_v, clr_v, eq_v;
    logic [LANES-1:0][CW-1:0]  cmp_v, cnt_v;
    logic                      tick_lo, src_hi;
    logic                      hit_lo, hit_hi, wrap_lo, full_hit;

    // Mode decode and per-lane run gating.
    always_comb begin
        casc     = (mode == MODE_CASC);
        run_v[0] = casc ? (run_lo & run_hi) : run_lo;
        run_v[1] = casc ? (run_lo & run_hi) : run_hi;
        cmp_v[0] = cmp_lo;
        cmp_v[1] = cmp_hi;
    end

    assign tick_lo = tick_in[sel_lo];

    tmr_src_sel #(.NT(NT)) u_src (
        .ticks   (tick_in[NT-1:1]),
        .sel     (sel_hi),
        .casc_ev (hit_lo),
        .src     (src_hi)
    );

    // Step enables, compare events and clears for both lanes.
    always_comb begin
        inc_v[0] = run_v[0] & tick_lo;
        hit_lo   = inc_v[0] & eq_v[0];
        wrap_lo  = inc_v[0] & (&cnt_v[0]);
        inc_v[1] = casc ? wrap_lo : (run_v[1] & src_hi);
        hit_hi   = inc_v[1] & eq_v[1];
        full_hit = inc_v[0] & eq_v[0] & eq_v[1];
        clr_v[0] = casc ? full_hit : hit_lo;
        clr_v[1] = casc ? full_hit : hit_hi;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tmr_byte_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_v[g]),
            .inc   (inc_v[g]),
            .clr   (clr_v[g]),
            .cmp   (cmp_v[g]),
            .cnt   (cnt_v[g]),
            .eq    (eq_v[g])
        );
    end

    assign cnt_lo = cnt_v[0];
    assign cnt_hi = cnt_v[1];

    // Registered event strobes, one cycle per match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_lo <= 1'b0;
            match_hi <= 1'b0;
            irq_lo   <= 1'b0;
            irq_hi   <= 1'b0;
        end else begin
            match_lo <= hit_lo;
            irq_lo   <= hit_lo & ~casc;
            match_hi <= casc ? full_hit : hit_hi;
            irq_hi   <= casc ? full_hit : hit_hi;
        end
    end
endmodule

// File: rtl/dual_tmr8_chk.sv
// Checker for dual_tmr8: port-level timing rules, bound to every instance.
// Assumes synchronous active-low reset; all properties are off during reset.
module dual_tmr8_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          run_lo,
    input logic [CW-1:0] cnt_lo,
    input logic [CW-1:0] cnt_hi,
    input logic          irq_lo,
    input logic          irq_hi
);
    assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_lo) |=> (cnt_lo == '0));

    assert_irq_lo_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (cnt_lo == '0));

    assert_irq_hi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (cnt_hi == '0));

    assert_no_irq_lo_casc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> !irq_lo);

    assert_step_or_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_lo != $past(cnt_lo)) |-> ((cnt_lo == $past(cnt_lo) + 1'b1) || (cnt_lo == '0)));

    assert_hi_on_roll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode) == 2'b01) && (cnt_hi != $past(cnt_hi))) |-> (cnt_lo == '0));
endmodule

bind dual_tmr8 dual_tmr8_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .run_lo (run_lo),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .irq_lo (irq_lo),
    .irq_hi (irq_hi)
);

// File: tb/tb_dual_tmr8.sv
`timescale 1ns/1ps
module tb_dual_tmr8;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] tick_in;
    logic [1:0] sel_lo, sel_hi, mode;
    logic       run_lo, run_hi;
    logic [7:0] cmp_lo, cmp_hi;
    logic [7:0] cnt_lo, cnt_hi;
    logic       match_lo, match_hi, irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dual_tmr8 dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .mode(mode), .run_lo(run_lo), .run_hi(run_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .match_lo(match_lo), .match_hi(match_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; one posedge consumes the tick mask.
    task automatic pulse(input logic [3:0] m);
        tick_in = m;
        @(negedge clk);
        tick_in = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_in = '0; sel_lo = 2'd0; sel_hi = 2'd1; mode = 2'b00;
        run_lo = 1'b1; run_hi = 1'b1; cmp_lo = 8'd5; cmp_hi = 8'd2;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 cnt_lo in reset", cnt_lo, 0);
        check("R1 irq_hi in reset", irq_hi, 0);
        do_reset();
        check("R1 cnt_lo after reset", cnt_lo, 0);
        check("R1 cnt_hi after reset", cnt_hi, 0);
        check("R1 strobes after reset", {match_lo, match_hi, irq_lo, irq_hi}, 0);
    endtask

    task automatic t_split_basic();
        int first = -1;
        do_reset();
        for (int i = 1; i <= 5; i++) begin
            pulse(4'b0001);
            if (i == 4) check("R2 count after 4 ticks", cnt_lo, 4);
            if (irq_lo && first < 0) first = i;
        end
        check("R2 match on 5th tick", first, 5);
        check("R2 match_lo with irq", match_lo, 1);
        check("R2 clear on match", cnt_lo, 0);
        @(negedge clk);
        check("R2 one-cycle pulse", irq_lo, 0);
    endtask

    task automatic t_zero_cmp();
        int hits = 0;
        int last = -1;
        do_reset();
        cmp_lo = 8'h00;
        for (int i = 1; i <= 256; i++) begin
            pulse(4'b0001);
            if (irq_lo) begin hits++; last = i; end
        end
        check("R3 one match in 256 ticks", hits, 1);
        check("R3 match on 256th tick", last, 256);
    endtask

    task automatic t_cascade8();
        int hits = 0;
        int last = -1;
        do_reset();
        sel_hi = 2'd0;
        for (int i = 1; i <= 10; i++) begin
            pulse(4'b0001);
            if (i == 5) check("R5 upper steps on lower match", cnt_hi, 1);
            if (irq_hi) begin hits++; last = i; end
        end
        check("R5 product period hits", hits, 1);
        check("R5 product period tick", last, 10);
        pulse(4'b0010);
        check("R4 sel_hi=0 ignores tick_in[1]", cnt_hi, 0);
    endtask

    task automatic t_upper_own();
        do_reset();
        mode = 2'b10;
        sel_hi = 2'd2;
        pulse(4'b0100);
        pulse(4'b0100);
        check("R4 upper counts tick_in[2]", cnt_hi, 0);
        check("R4 upper match on own tick", irq_hi, 1);
        pulse(4'b0001);
        check("R4 lower ignores upper tick path", cnt_hi, 0);
        check("R6 mode 2'b10 acts split", cnt_lo, 1);
    endtask

    task automatic t_casc16();
        int lo_irq = 0;
        int hi_irq = 0;
        do_reset();
        mode = 2'b01; sel_hi = 2'd1; cmp_hi = 8'h01; cmp_lo = 8'h03;
        for (int i = 1; i <= 258; i++) begin
            pulse(4'b0001);
            if (i == 255) check("R6 no upper step before roll", cnt_hi, 0);
            if (irq_lo) lo_irq++;
            if (irq_hi) hi_irq++;
        end
        check("R7 no irq before 16-bit match", hi_irq, 0);
        check("R6 upper after roll-over", cnt_hi, 1);
        check("R6 lower after 258 ticks", cnt_lo, 2);
        pulse(4'b0010);
        check("R6 sel_hi ignored in cascade", cnt_hi, 1);
        pulse(4'b0001);
        check("R7 irq_hi on 16-bit match", irq_hi, 1);
        check("R7 both lanes clear", {cnt_hi, cnt_lo}, 0);
        check("R7 irq_lo silent in cascade", lo_irq + irq_lo, 0);
        run_hi = 1'b0;
        pulse(4'b0001);
        check("R8 cascade needs both run bits", cnt_lo, 0);
    endtask

    task automatic t_run();
        do_reset();
        cmp_lo = 8'd20;
        pulse(4'b0001); pulse(4'b0001); pulse(4'b0001);
        run_lo = 1'b0;
        @(negedge clk);
        check("R8 run low clears", cnt_lo, 0);
        pulse(4'b0001);
        check("R8 ticks ignored while stopped", cnt_lo, 0);
        run_lo = 1'b1;
        pulse(4'b0001);
        check("R8 restart from zero", cnt_lo, 1);
    endtask

    task automatic t_cmp_change();
        do_reset();
        cmp_lo = 8'd10;
        pulse(4'b0001); pulse(4'b0001); pulse(4'b0001);
        check("R9 count before change", cnt_lo, 3);
        cmp_lo = 8'd4;
        pulse(4'b0001);
        check("R9 new compare applies at once", irq_lo, 1);
        check("R9 clear with new compare", cnt_lo, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; tick_in = '0; sel_lo = '0; sel_hi = '0; mode = '0;
        run_lo = 1'b0; run_hi = 1'b0; cmp_lo = '0; cmp_hi = '0;
        @(negedge clk);
        t_reset();
        t_split_basic();
        t_zero_cmp();
        t_cascade8();
        t_upper_own();
        t_casc16();
        t_run();
        t_cmp_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule